// File: doc/BRIEF.md
# Precise Trap Dispatcher

This block decides, once per processor cycle, whether the pipeline may advance or whether a trap must be taken first. Each cycle it looks at three sources of work: a halt request, a vector of pending exception classes, and a vector of pending interrupt levels. Interrupts are gated by an enable and by the current interrupt priority level. When it accepts a trap, the block does the following:

- stalls advancement for that whole cycle;
- flushes every pipeline slot;
- clears this CPU's load-locked/store-conditional reservation;
- latches the faulting PC into an exception-address register;
- computes the handler entry as a privileged base address plus an offset chosen by the trap.

Fetch is then redirected to that entry, and handler code runs through the ordinary pipeline. Some exception classes must first see the write buffers emptied. For those classes the block raises a drain request, holds it until the memory side acknowledges, and only then issues the redirect. A halt request does not take a trap. It parks the block in a halted state, and the block stays there until reset.

Top module: `trap_dispatch`

## Requirements
- R1: In a cycle where a trap is accepted, `flush` is high and `advance` is low in that same cycle. `advance` is high only in the running state, with no halt request and no accepted trap.
- R2: An interrupt at level L is pending when `irq_pend[L]` is 1. It is deliverable only when `irq_enable` is 1 and L > `cur_ipl`, so bit 0 is never deliverable. Among pending levels the highest wins, and it is reported on `trap_num` with `trap_is_irq` high.
- R3: Exceptions come before interrupts. Among pending exception classes the lowest-numbered class wins and is reported on `trap_num` with `trap_is_irq` low. At most one trap is accepted per cycle.
- R4: When `irq_enable` is low, no interrupt is accepted, and exceptions are still accepted.
- R5: On acceptance, `exc_addr` takes the value of `exc_pc` from the accept cycle, starting in the next cycle. It holds that value until the next acceptance. Its reset value is 0.
- R6: `resv_clear` is a one-cycle pulse asserted exactly in the accept cycle.
- R7: `redirect_pc` is `pal_base` (sampled in the accept cycle) plus an offset. The offset is 0 for an interrupt and (c+1)*2^VEC_SHIFT for exception class c, which is (c+1)*128 by default.
- R8: Exception class c needs a drain when DRAIN_MASK[c] is 1 (default: classes 4 to 7). For such a class, `drain_req` rises in the cycle after acceptance and stays high through the cycle in which `drain_done` is seen high. `redirect_valid` pulses in the following cycle.
- R9: For a trap without a drain, `redirect_valid` is a one-cycle pulse in the cycle after acceptance.
- R10: While a drain is outstanding, and in the redirect cycle, no new trap is accepted and `advance` stays low. All requests are ignored.
- R11: A halt request in the running state wins over any pending trap. No trap is accepted in that cycle. From the next cycle `halted` is high, and it stays high with no advance and no trap until reset.
- R12: After reset, `halted`, `drain_req`, `redirect_valid` and `exc_addr` are 0. `advance` is high when no request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| halt_req | input | 1 | Request to stop the run loop |
| irq_enable | input | 1 | Global interrupt enable |
| irq_pend | input | IRQ_N | Pending interrupt levels, bit index = level |
| cur_ipl | input | IPL_W | Current interrupt priority level |
| exc_pend | input | EXC_N | Pending exception classes, bit index = class |
| exc_pc | input | PC_W | PC of the faulting or interrupted instruction |
| pal_base | input | PC_W | Privileged handler base address |
| drain_done | input | 1 | Write buffers are empty |
| advance | output | 1 | Pipeline may advance this cycle |
| flush | output | 1 | Flush all pipeline slots (accept cycle) |
| resv_clear | output | 1 | Break this CPU's LL/SC reservation |
| trap_is_irq | output | 1 | Accepted trap is an interrupt |
| trap_num | output | NUM_W | Accepted interrupt level or exception class |
| redirect_valid | output | 1 | Redirect fetch to `redirect_pc` |
| redirect_pc | output | PC_W | Handler entry address |
| drain_req | output | 1 | Request a write-buffer drain |
| halted | output | 1 | Run loop stopped |
| exc_addr | output | PC_W | Saved faulting PC |

## Verification
The hardest situation to reach from the ports is a drain that stays outstanding while new exceptions, interrupts and halt requests keep arriving. The block has to ignore all of them and still release the redirect on the acknowledge. Directed cases delay `drain_done` for several cycles and raise every request during that wait. A long random phase then combines sparse exceptions from drain and non-drain classes with random acknowledges, levels and enables, so that busy windows overlap with back-to-back requests. The reference model in the bench predicts every output on every cycle.

// File: rtl/td_pkg.sv
package td_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_REDIR = 2'd2,
    ST_HALT  = 2'd3
  } td_state_e;

  // Highest set bit index; 0 when the vector is empty.
  function automatic int unsigned top_index(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // Lowest set bit index; 0 when the vector is empty.
  function automatic int unsigned low_index(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = i;
    end
    return r;
  endfunction

  // Handler offset: interrupts share entry 0, exception class c uses slot c+1.
  function automatic logic [31:0] vec_offset(input logic is_irq,
                                             input int unsigned cls,
                                             input int unsigned shift);
    if (is_irq) return 32'd0;
    return (cls + 1) << shift;
  endfunction

endpackage

// File: rtl/td_irq_arb.sv
module td_irq_arb #(
  parameter int IRQ_N = 16,
  localparam int LVL_W = $clog2(IRQ_N)
) (
  input  logic [IRQ_N-1:0] pend,
  input  logic [LVL_W-1:0] ipl,
  input  logic             enable,
  output logic             hit,
  output logic [LVL_W-1:0] level
);
  import td_pkg::*;

  int unsigned best;

  always_comb begin
    best  = top_index(32'(pend));
    level = LVL_W'(best);
    // Highest pending level decides: if it is not above ipl, none is.
    hit   = enable && (pend != '0) && (best > 32'(ipl));
  end
endmodule

// File: rtl/td_exc_arb.sv
module td_exc_arb #(
  parameter int EXC_N = 8,
  localparam int CLS_W = $clog2(EXC_N)
) (
  input  logic [EXC_N-1:0] pend,
  output logic             hit,
  output logic [CLS_W-1:0] cls
);
  import td_pkg::*;

  always_comb begin
    hit = |pend;
    cls = CLS_W'(low_index(32'(pend)));
  end
endmodule

// File: rtl/td_vector.sv
module td_vector #(
  parameter int PC_W      = 32,
  parameter int CLS_W     = 3,
  parameter int VEC_SHIFT = 7
) (
  input  logic             is_irq,
  input  logic [CLS_W-1:0] cls,
  input  logic [PC_W-1:0]  base,
  output logic [PC_W-1:0]  entry
);
  import td_pkg::*;

  logic [31:0] off;

  always_comb begin
    off   = vec_offset(is_irq, 32'(cls), VEC_SHIFT);
    entry = base + PC_W'(off);
  end
endmodule

// File: rtl/trap_dispatch.sv
module trap_dispatch #(
  parameter int             IRQ_N      = 16,
  parameter int             EXC_N      = 8,
  parameter int             PC_W       = 32,
  parameter int             VEC_SHIFT  = 7,
  parameter logic [EXC_N-1:0] DRAIN_MASK = 8'hF0,
  localparam int IPL_W = $clog2(IRQ_N),
  localparam int CLS_W = $clog2(EXC_N),
  localparam int NUM_W = (IPL_W > CLS_W) ? IPL_W : CLS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_req,
  input  logic             irq_enable,
  input  logic [IRQ_N-1:0] irq_pend,
  input  logic [IPL_W-1:0] cur_ipl,
  input  logic [EXC_N-1:0] exc_pend,
  input  logic [PC_W-1:0]  exc_pc,
  input  logic [PC_W-1:0]  pal_base,
  input  logic             drain_done,
  output logic             advance,
  output logic             flush,
  output logic             resv_clear,
  output logic             trap_is_irq,
  output logic [NUM_W-1:0] trap_num,
  output logic             redirect_valid,
  output logic [PC_W-1:0]  redirect_pc,
  output logic             drain_req,
  output logic             halted,
  output logic [PC_W-1:0]  exc_addr
);
  import td_pkg::*;

  td_state_e        st;
  logic             irq_hit, exc_hit, in_run, accept, needs_drain;
  logic [IPL_W-1:0] irq_level;
  logic [CLS_W-1:0] exc_cls;
  logic [PC_W-1:0]  vec_addr;

  td_irq_arb #(.IRQ_N(IRQ_N)) u_irq (
    .pend(irq_pend), .ipl(cur_ipl), .enable(irq_enable),
    .hit(irq_hit), .level(irq_level)
  );

  td_exc_arb #(.EXC_N(EXC_N)) u_exc (
    .pend(exc_pend), .hit(exc_hit), .cls(exc_cls)
  );

  td_vector #(.PC_W(PC_W), .CLS_W(CLS_W), .VEC_SHIFT(VEC_SHIFT)) u_vec (
    .is_irq(!exc_hit), .cls(exc_cls), .base(pal_base), .entry(vec_addr)
  );

  always_comb begin
    in_run         = (st == ST_RUN);
    accept         = in_run && !halt_req && (exc_hit || irq_hit);
    needs_drain    = exc_hit && DRAIN_MASK[exc_cls];
    advance        = in_run && !halt_req && !accept;
    flush          = accept;
    resv_clear     = accept;
    trap_is_irq    = accept && !exc_hit;
    if (!accept)      trap_num = '0;
    else if (exc_hit) trap_num = NUM_W'(exc_cls);
    else              trap_num = NUM_W'(irq_level);
    drain_req      = (st == ST_DRAIN);
    redirect_valid = (st == ST_REDIR);
    halted         = (st == ST_HALT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_RUN;
      exc_addr    <= '0;
      redirect_pc <= '0;
    end else begin
      case (st)
        ST_RUN: begin
          if (halt_req) begin
            st <= ST_HALT;
          end else if (accept) begin
            exc_addr    <= exc_pc;
            redirect_pc <= vec_addr;
            st          <= needs_drain ? ST_DRAIN : ST_REDIR;
          end
        end
        ST_DRAIN: if (drain_done) st <= ST_REDIR;
        ST_REDIR: st <= ST_RUN;
        default:  st <= ST_HALT;
      endcase
    end
  end
endmodule

// File: rtl/td_checker.sv
module td_checker #(
  parameter int IPL_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             advance,
  input logic             flush,
  input logic             resv_clear,
  input logic             trap_is_irq,
  input logic [IPL_W-1:0] irq_level,
  input logic [IPL_W-1:0] cur_ipl,
  input logic             exc_hit,
  input logic             redirect_valid,
  input logic             drain_req,
  input logic             drain_done,
  input logic             halted
);
  AST_TRAP_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !advance); // R1
  AST_IRQ_ABOVE_IPL: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && trap_is_irq) |-> (irq_level > cur_ipl)); // R2
  AST_EXC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && exc_hit) |-> !trap_is_irq); // R3
  AST_RESV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resv_clear |=> !resv_clear); // R6
  AST_DRAIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_req && !drain_done) |=> drain_req); // R8
  AST_DRAIN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drain_req) |-> (redirect_valid && $past(drain_done))); // R8
  AST_REDIR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !redirect_valid); // R9
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_req || redirect_valid) |-> (!flush && !advance)); // R10
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !flush && !advance)); // R11
endmodule

bind trap_dispatch td_checker #(.IPL_W(IPL_W)) u_td_checker (
  .clk(clk), .rst_n(rst_n), .advance(advance), .flush(flush),
  .resv_clear(resv_clear), .trap_is_irq(trap_is_irq),
  .irq_level(irq_level), .cur_ipl(cur_ipl), .exc_hit(exc_hit),
  .redirect_valid(redirect_valid), .drain_req(drain_req),
  .drain_done(drain_done), .halted(halted)
);

// File: tb/tb_trap_dispatch.sv
`timescale 1ns/1ps
module tb_trap_dispatch;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        halt_req = 0, irq_enable = 0, drain_done = 0;
  logic [15:0] irq_pend = 0;
  logic [3:0]  cur_ipl = 0;
  logic [7:0]  exc_pend = 0;
  logic [31:0] exc_pc = 0, pal_base = 0;
  logic        advance, flush, resv_clear, trap_is_irq, redirect_valid, drain_req, halted;
  logic [3:0]  trap_num;
  logic [31:0] redirect_pc, exc_addr;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  trap_dispatch dut (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .irq_enable(irq_enable),
    .irq_pend(irq_pend), .cur_ipl(cur_ipl), .exc_pend(exc_pend), .exc_pc(exc_pc),
    .pal_base(pal_base), .drain_done(drain_done), .advance(advance), .flush(flush),
    .resv_clear(resv_clear), .trap_is_irq(trap_is_irq), .trap_num(trap_num),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .drain_req(drain_req),
    .halted(halted), .exc_addr(exc_addr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: 0 running, 1 draining, 2 redirecting, 3 halted
  int          m_st = 0;
  logic [31:0] m_epc = 0, m_vec = 0;

  always @(negedge clk) begin
    bit e_take, e_irq, e_adv;
    int e_num;
    string ftag;
    if (!rst_n) begin
      m_st = 0; m_epc = 0; m_vec = 0;
    end else begin
      e_take = 0; e_irq = 0; e_num = 0;
      if (m_st == 0 && !halt_req) begin
        for (int c = 0; c < 8; c++)
          if (exc_pend[c] && !e_take) begin e_take = 1; e_num = c; end
        if (!e_take && irq_enable)
          for (int l = 15; l >= 1; l--)
            if (irq_pend[l] && l > cur_ipl && !e_take) begin e_take = 1; e_irq = 1; e_num = l; end
      end
      e_adv = (m_st == 0) && !halt_req && !e_take;
      if (m_st != 0) ftag = "R10";
      else if (!irq_enable && irq_pend != 0 && exc_pend == 0) ftag = "R4";
      else ftag = "R3";
      chk(advance == e_adv, "R1 advance", 32'(advance), 32'(e_adv));
      chk(flush == e_take, {ftag, " flush"}, 32'(flush), 32'(e_take));
      chk(resv_clear == e_take, "R6 resv_clear", 32'(resv_clear), 32'(e_take));
      if (e_take) begin
        chk(trap_is_irq == e_irq, "R2 trap_is_irq", 32'(trap_is_irq), 32'(e_irq));
        chk(trap_num == 4'(e_num), e_irq ? "R2 level" : "R3 class", 32'(trap_num), 32'(e_num));
      end
      chk(drain_req == (m_st == 1), "R8 drain_req", 32'(drain_req), 32'(m_st == 1));
      chk(redirect_valid == (m_st == 2), "R9 redirect_valid", 32'(redirect_valid), 32'(m_st == 2));
      if (m_st == 2) chk(redirect_pc == m_vec, "R7 redirect_pc", redirect_pc, m_vec);
      chk(halted == (m_st == 3), "R11 halted", 32'(halted), 32'(m_st == 3));
      chk(exc_addr == m_epc, "R5 exc_addr", exc_addr, m_epc);
      // next state
      case (m_st)
        0: if (halt_req) m_st = 3;
           else if (e_take) begin
             m_epc = exc_pc;
             m_vec = pal_base + (e_irq ? 32'd0 : (e_num + 1) * 128);
             m_st  = (!e_irq && e_num >= 4) ? 1 : 2;
           end
        1: if (drain_done) m_st = 2;
        2: m_st = 0;
        default: m_st = 3;
      endcase
    end
  end

  task automatic cyc(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_req();
    irq_pend = 0; exc_pend = 0; halt_req = 0; drain_done = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    pal_base = 32'h8000_0000; exc_pc = 32'h1000;
    cyc(3);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk(halted == 0 && drain_req == 0 && redirect_valid == 0, "R12 control outputs",
        {29'd0, halted, drain_req, redirect_valid}, 0);
    chk(exc_addr == 0, "R12 exc_addr", exc_addr, 0);
    chk(advance == 1, "R12 advance", 32'(advance), 1);
    cyc(2);
    // R2: level 5 above ipl 3
    irq_enable = 1; cur_ipl = 3; irq_pend = 16'h0020; exc_pc = 32'h1111_0000;
    cyc(1); clear_req(); cyc(3);
    // R2: level equal to ipl is not taken, bit 0 never
    irq_pend = 16'h0009; cur_ipl = 3; cyc(3); clear_req();
    // R2: highest of several wins
    irq_pend = 16'h0244; cur_ipl = 4; exc_pc = 32'h2222_0000; cyc(1); clear_req(); cyc(2);
    // R4: masked
    irq_enable = 0; irq_pend = 16'h8000; cur_ipl = 0; cyc(3);
    exc_pend = 8'h02; exc_pc = 32'h3333_0000; cyc(1); clear_req(); cyc(2);
    irq_enable = 1;
    // R3: exception beats interrupt, lowest class wins (non-drain class 3)
    exc_pend = 8'h48; irq_pend = 16'h8000; exc_pc = 32'h4444_0000; cyc(1); clear_req(); cyc(2);
    // R8/R10: drain class 5, late acknowledge, requests during drain ignored
    exc_pend = 8'h20; exc_pc = 32'h5555_0000; cyc(1);
    exc_pend = 8'h01; irq_pend = 16'hFFFE; halt_req = 1; cyc(4);
    halt_req = 0; drain_done = 1; cyc(1); drain_done = 0; cyc(1); clear_req(); cyc(2);
    // R7: max ipl blocks all, then top class 7 offset
    cur_ipl = 15; irq_pend = 16'hFFFF; cyc(2); clear_req();
    pal_base = 32'h0001_0000; exc_pend = 8'h80; drain_done = 1; cyc(1); clear_req(); cyc(3);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      irq_pend   = 16'($urandom);
      cur_ipl    = 4'($urandom);
      irq_enable = ($urandom % 4) != 0;
      exc_pend   = (($urandom % 5) == 0) ? 8'(1 << ($urandom % 8)) | 8'($urandom % 2 ? 0 : $urandom) : 8'h00;
      drain_done = ($urandom % 3) == 0;
      exc_pc     = $urandom;
      pal_base   = $urandom & 32'hFFFF_F000;
      cyc(1);
    end
    clear_req(); drain_done = 1; cyc(4); drain_done = 0;
    // R11: halt beats a pending exception and sticks
    exc_pend = 8'h01; halt_req = 1; cyc(1); halt_req = 0; irq_pend = 16'hFFFF; cur_ipl = 0; cyc(5);
    @(negedge clk);
    chk(halted == 1, "R11 halt sticky", 32'(halted), 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule